// File: doc/BRIEF.md
# Stream Register Snoop Filter

This block sits beside a local cache and decides, for each snoop arriving from the interconnect, whether the cache's tag array needs to be looked up at all. It keeps a small bank of stream registers. Each register holds a base line address and a care-mask. Together the registers describe a superset of the lines the cache may hold. A snoop whose address falls outside every described range cannot hit in the cache, so its tag lookup is skipped.

Each line the cache allocates is reported together with the set it went into. The address is placed in a free register, or else merged into the register that gives up the fewest mask bits. Merging keeps the superset correct but coarser, so over time the registers saturate. To shed stale coverage, the block counts replacements per set. Once every set has replaced at least one more line than it has ways, the whole cache has turned over, and this is called a wrap. At a wrap the working registers move to a shadow bank and the working bank starts empty. Lookups use both banks. The next wrap overwrites the shadow bank, which drops coverage that is two generations old.

A two-state generation machine controls the shadow bank. State `GEN_FRESH` holds after reset, and no shadow entry exists. Transition `FIRST_ROTATE` goes from `GEN_FRESH` to `GEN_SHADOWED` on the first wrap. Transition `ROTATE` goes from `GEN_SHADOWED` back to itself on every later wrap. Without a wrap, each state holds.

Top module: `stream_snoop_filter`

## Requirements
- R1: A snoop is forwarded for lookup (`fwd_lookup`=1) when some valid register has a base equal to the snoop address on every bit where that register's mask is 1. Otherwise it is filtered (`fwd_lookup`=0).
- R2: An allocation goes into the lowest-index empty register when one exists. That register is loaded with base = address and an all-ones mask.
- R3: When no register is empty, the allocation goes into the register whose mask would lose the fewest bits. Ties go to the lowest index. That register's mask is cleared on every bit where the address differs from its base.
- R4: Each set has a replacement counter that goes up by one on each allocation to that set and stops at ways+1.
- R5: A wrap happens on the allocation that leaves every set's counter at ways+1. All counters then return to zero.
- R6: At a wrap, the working bank moves to the shadow bank and the working bank is cleared. The move includes the allocation that caused the wrap. Lookups use the union of both banks.
- R7: At each later wrap, the previous shadow contents are discarded and replaced.
- R8: `fwd_valid` is high exactly one cycle after `snoop_valid`. The decision uses the register contents from before any allocation in the same cycle.
- R9: Reset empties both banks, clears the counters, enters `GEN_FRESH` and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A line was allocated this cycle |
| alloc_set | input | $clog2(NUM_SETS) | Set index of the allocated line |
| alloc_addr | input | ADDR_W | Line address of the allocated line |
| snoop_valid | input | 1 | Snoop presented this cycle |
| snoop_addr | input | ADDR_W | Snoop line address |
| fwd_valid | output | 1 | Decision valid, one cycle after the snoop |
| fwd_lookup | output | 1 | 1 = forward to tag lookup, 0 = filtered |

## Verification
The bench uses an 8-bit line address, four registers, four sets and two ways. With these values each generation needs only twelve allocations to reach a wrap, so two full rotations fit in a short run. The 2-bit counters would roll over on a fourth allocation to one set, which exposes the saturation rule. With four registers the bank fills after four distinct lines, which brings the fewest-lost-bits merge and the lowest-index tie within a handful of steps.

// File: rtl/sf_pkg.sv
package sf_pkg;

    // generation state of the shadow bank
    typedef enum logic [0:0] {
        GEN_FRESH    = 1'b0,
        GEN_SHADOWED = 1'b1
    } gen_state_t;

endpackage

// File: rtl/sf_match.sv
module sf_match #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4
) (
    input  logic                             enable,
    input  logic [NUM_REGS-1:0]              reg_valid,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0]  reg_base,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0]  reg_mask,
    input  logic [ADDR_W-1:0]                addr,
    output logic                             hit
);

    logic [NUM_REGS-1:0] hit_vec;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
        assign hit_vec[i] = enable && reg_valid[i] &&
                            (((addr ^ reg_base[i]) & reg_mask[i]) == '0);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/sf_victim_pick.sv
module sf_victim_pick #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4,
    localparam int IW = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0]              reg_valid,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0]  reg_base,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0]  reg_mask,
    input  logic [ADDR_W-1:0]                addr,
    output logic [IW-1:0]                    pick_idx,
    output logic                             pick_empty
);

    localparam int CW = $clog2(ADDR_W + 2);

    logic [NUM_REGS-1:0][CW-1:0] cost;
    logic [CW-1:0]               best_cost;

    // bits each register would give up if it absorbed the address
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cost
        assign cost[i] = CW'($countones(reg_mask[i] & (reg_base[i] ^ addr)));
    end

    always_comb begin
        pick_idx   = '0;
        pick_empty = 1'b0;
        best_cost  = CW'(ADDR_W + 1);
        // descending walk leaves the lowest free index
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (!reg_valid[i]) begin
                pick_idx   = IW'(i);
                pick_empty = 1'b1;
            end
        end
        if (!pick_empty) begin
            // strict less-than keeps the lowest index on ties
            for (int i = 0; i < NUM_REGS; i++) begin
                if (cost[i] < best_cost) begin
                    best_cost = cost[i];
                    pick_idx  = IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/sf_wrap_tracker.sv
module sf_wrap_tracker #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 2,
    localparam int SW = $clog2(NUM_SETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [SW-1:0] alloc_set,
    output logic          wrap_evt
);

    localparam int CTR_W = $clog2(NUM_WAYS + 2);
    localparam logic [CTR_W-1:0] LIMIT = CTR_W'(NUM_WAYS + 1);

    logic [NUM_SETS-1:0][CTR_W-1:0] cnt_q, cnt_inc;
    logic                            all_full;

    always_comb begin
        cnt_inc = cnt_q;
        if (alloc_valid && cnt_q[alloc_set] != LIMIT) begin
            cnt_inc[alloc_set] = cnt_q[alloc_set] + 1'b1;
        end
        all_full = 1'b1;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (cnt_inc[s] != LIMIT) begin
                all_full = 1'b0;
            end
        end
    end

    assign wrap_evt = alloc_valid && all_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap_evt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
        // R4: a counter never passes its ceiling
        a_r4_ctr_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[s] <= LIMIT);
    end

    // R5: the cycle after a wrap every counter reads zero
    a_r5_ctr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (cnt_q == '0));

endmodule

// File: rtl/stream_snoop_filter.sv
module stream_snoop_filter #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4,
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [$clog2(NUM_SETS)-1:0] alloc_set,
    input  logic [ADDR_W-1:0]           alloc_addr,
    input  logic                        snoop_valid,
    input  logic [ADDR_W-1:0]           snoop_addr,
    output logic                        fwd_valid,
    output logic                        fwd_lookup
);
    import sf_pkg::*;

    localparam int IW = $clog2(NUM_REGS);

    gen_state_t gen_q, gen_d;

    logic [NUM_REGS-1:0]             act_valid_q, shd_valid_q, upd_valid;
    logic [NUM_REGS-1:0][ADDR_W-1:0] act_base_q, act_mask_q;
    logic [NUM_REGS-1:0][ADDR_W-1:0] shd_base_q, shd_mask_q;
    logic [NUM_REGS-1:0][ADDR_W-1:0] upd_base, upd_mask;

    logic [IW-1:0] pick_idx;
    logic          pick_empty;
    logic          wrap_evt;
    logic          act_hit, shd_hit, shd_en;

    sf_victim_pick #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_pick (
        .reg_valid  (act_valid_q),
        .reg_base   (act_base_q),
        .reg_mask   (act_mask_q),
        .addr       (alloc_addr),
        .pick_idx   (pick_idx),
        .pick_empty (pick_empty)
    );

    sf_wrap_tracker #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_wrap (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .alloc_set   (alloc_set),
        .wrap_evt    (wrap_evt)
    );

    assign shd_en = (gen_q == GEN_SHADOWED);

    sf_match #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_act_match (
        .enable    (1'b1),
        .reg_valid (act_valid_q),
        .reg_base  (act_base_q),
        .reg_mask  (act_mask_q),
        .addr      (snoop_addr),
        .hit       (act_hit)
    );

    sf_match #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_shd_match (
        .enable    (shd_en),
        .reg_valid (shd_valid_q),
        .reg_base  (shd_base_q),
        .reg_mask  (shd_mask_q),
        .addr      (snoop_addr),
        .hit       (shd_hit)
    );

    // working bank after absorbing this cycle's allocation
    always_comb begin
        upd_valid = act_valid_q;
        upd_base  = act_base_q;
        upd_mask  = act_mask_q;
        if (alloc_valid) begin
            upd_valid[pick_idx] = 1'b1;
            if (pick_empty) begin
                upd_base[pick_idx] = alloc_addr;
                upd_mask[pick_idx] = '1;
            end else begin
                upd_mask[pick_idx] = act_mask_q[pick_idx] &
                                     ~(act_base_q[pick_idx] ^ alloc_addr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid_q <= '0;
            act_base_q  <= '0;
            act_mask_q  <= '0;
            shd_valid_q <= '0;
            shd_base_q  <= '0;
            shd_mask_q  <= '0;
        end else if (wrap_evt) begin
            shd_valid_q <= upd_valid;
            shd_base_q  <= upd_base;
            shd_mask_q  <= upd_mask;
            act_valid_q <= '0;
            act_base_q  <= '0;
            act_mask_q  <= '0;
        end else begin
            act_valid_q <= upd_valid;
            act_base_q  <= upd_base;
            act_mask_q  <= upd_mask;
        end
    end

    // generation machine: next state
    always_comb begin
        gen_d = gen_q;
        unique case (gen_q)
            GEN_FRESH:    if (wrap_evt) gen_d = GEN_SHADOWED; // FIRST_ROTATE
            GEN_SHADOWED: if (wrap_evt) gen_d = GEN_SHADOWED; // ROTATE
        endcase
    end

    // generation machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= GEN_FRESH;
        else        gen_q <= gen_d;
    end

    // outputs: registered decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid  <= 1'b0;
            fwd_lookup <= 1'b0;
        end else begin
            fwd_valid  <= snoop_valid;
            fwd_lookup <= snoop_valid && (act_hit || shd_hit);
        end
    end

    function automatic logic bank_covers(
        input logic [NUM_REGS-1:0]             v,
        input logic [NUM_REGS-1:0][ADDR_W-1:0] b,
        input logic [NUM_REGS-1:0][ADDR_W-1:0] m,
        input logic [ADDR_W-1:0]               a
    );
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (v[i] && (((a ^ b[i]) & m[i]) == '0)) r = 1'b1;
        end
        return r;
    endfunction

    // R8: a decision follows every snoop one cycle later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |=> fwd_valid);

    // R8: no decision without a snoop
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |=> (!fwd_valid && !fwd_lookup));

    // R2/R3: an allocated line is covered by the working bank next cycle
    a_r2_alloc_covered: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !wrap_evt) |=>
        bank_covers(act_valid_q, act_base_q, act_mask_q, $past(alloc_addr)));

    // R6: a wrap leaves the working bank empty and the shadow in use
    a_r6_bank_rotated: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (act_valid_q == '0 && gen_q == GEN_SHADOWED));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_mask_chk
        // R3: a live register's mask only loses bits between wraps
        a_r3_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
            (act_valid_q[i] && !wrap_evt) |=>
            ((act_mask_q[i] & ~$past(act_mask_q[i])) == '0));
    end

endmodule

// File: tb/sim_stream_snoop_filter.sv
`timescale 1ns/1ps
module sim_stream_snoop_filter;

    localparam int ADDR_W = 8;

    typedef struct packed {
        logic [1:0] kind;   // 0 alloc, 1 snoop, 2 both
        logic [1:0] set;
        logic [7:0] addr;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam logic [1:0] AL = 2'd0, SN = 2'd1, BO = 2'd2;
    localparam int NV = 45;

    localparam vec_t TBL [NV] = '{
        '{BO, 2'd0, 8'h11, 1'b0, 4'd8},  // R8: same-cycle alloc unseen
        '{SN, 2'd0, 8'h11, 1'b1, 4'd2},  // R2
        '{SN, 2'd0, 8'h13, 1'b0, 4'd1},  // R1
        '{AL, 2'd1, 8'h13, 1'b0, 4'd2},
        '{AL, 2'd2, 8'h40, 1'b0, 4'd2},
        '{AL, 2'd3, 8'h80, 1'b0, 4'd2},
        '{AL, 2'd0, 8'h15, 1'b0, 4'd3},  // R3: merge into reg 0
        '{SN, 2'd0, 8'h15, 1'b1, 4'd3},
        '{SN, 2'd0, 8'h17, 1'b0, 4'd3},
        '{SN, 2'd0, 8'h51, 1'b0, 4'd1},
        '{AL, 2'd1, 8'h41, 1'b0, 4'd3},
        '{SN, 2'd0, 8'h41, 1'b1, 4'd3},
        '{AL, 2'd2, 8'h12, 1'b0, 4'd3},
        '{AL, 2'd3, 8'h10, 1'b0, 4'd3},  // R3: tie, lowest index
        '{SN, 2'd0, 8'h14, 1'b1, 4'd3},
        '{SN, 2'd0, 8'h16, 1'b0, 4'd1},
        '{AL, 2'd0, 8'h11, 1'b0, 4'd5},
        '{AL, 2'd1, 8'h41, 1'b0, 4'd5},
        '{AL, 2'd2, 8'h12, 1'b0, 4'd5},
        '{SN, 2'd0, 8'h80, 1'b1, 4'd5},
        '{AL, 2'd3, 8'h10, 1'b0, 4'd5},  // R5: first wrap
        '{SN, 2'd0, 8'h14, 1'b1, 4'd6},
        '{SN, 2'd0, 8'h80, 1'b1, 4'd6},
        '{SN, 2'd0, 8'h22, 1'b0, 4'd6},
        '{AL, 2'd0, 8'h20, 1'b0, 4'd5},
        '{SN, 2'd0, 8'h80, 1'b1, 4'd5},  // R5: counters restarted
        '{SN, 2'd0, 8'h20, 1'b1, 4'd6},
        '{AL, 2'd0, 8'h20, 1'b0, 4'd4},
        '{AL, 2'd0, 8'h20, 1'b0, 4'd4},
        '{AL, 2'd0, 8'h20, 1'b0, 4'd4},  // R4: fourth to set 0
        '{AL, 2'd1, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd1, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd1, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd2, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd2, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd2, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd3, 8'hA0, 1'b0, 4'd4},
        '{AL, 2'd3, 8'hA0, 1'b0, 4'd4},
        '{SN, 2'd0, 8'h80, 1'b1, 4'd7},
        '{AL, 2'd3, 8'hA0, 1'b0, 4'd7},  // R7: second wrap
        '{SN, 2'd0, 8'h80, 1'b0, 4'd7},
        '{SN, 2'd0, 8'h14, 1'b0, 4'd7},
        '{SN, 2'd0, 8'hA0, 1'b1, 4'd6},
        '{SN, 2'd0, 8'h20, 1'b1, 4'd6},
        '{SN, 2'd0, 8'h21, 1'b0, 4'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic [1:0]       alloc_set = '0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic             snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic             fwd_valid, fwd_lookup;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    stream_snoop_filter #(
        .ADDR_W(ADDR_W), .NUM_REGS(4), .NUM_SETS(4), .NUM_WAYS(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_set(alloc_set), .alloc_addr(alloc_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .fwd_valid(fwd_valid), .fwd_lookup(fwd_lookup)
    );

    task automatic check(input logic got, input logic exp, input int req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    // called at a negedge; drives, lets one posedge pass, samples at the next negedge
    task automatic step(input vec_t v);
        alloc_valid = (v.kind == AL || v.kind == BO);
        snoop_valid = (v.kind == SN || v.kind == BO);
        alloc_set   = v.set;
        alloc_addr  = v.addr;
        snoop_addr  = v.addr;
        @(negedge clk);
        if (snoop_valid) begin
            check(fwd_valid, 1'b1, 8, $sformatf("valid for %h", v.addr));
            check(fwd_lookup, v.exp, int'(v.req), $sformatf("decision for %h", v.addr));
        end
        alloc_valid = 1'b0;
        snoop_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs low under reset
        check(fwd_valid, 1'b0, 9, "valid in reset");
        check(fwd_lookup, 1'b0, 9, "lookup in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(TBL[i]);
        end
        // R8: idle cycle gives no decision
        @(negedge clk);
        check(fwd_valid, 1'b0, 8, "valid when idle");
        // R9: mid-run reset empties both banks
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step('{SN, 2'd0, 8'h20, 1'b0, 4'd9});
        step('{SN, 2'd0, 8'hA0, 1'b0, 4'd9});
        // R2 after reset: a fresh line is covered again
        step('{AL, 2'd0, 8'h33, 1'b0, 4'd2});
        step('{SN, 2'd0, 8'h33, 1'b1, 4'd2});
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule